// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block turns the filtered input level of one general-purpose pin into interrupt and wake status, based on that pin's own configuration. The pin can be set to edge or level sensing. A two-bit polarity field selects low/falling, high/rising, or both edges. Separate bits enable detection and gate the request sent to the interrupt aggregator. The input is expected to be debounced already. Status bits are written by the bus logic that sits around the block.

Both status bits are sticky. The interrupt status bit sets only when detection is enabled. The wake status bit sets on the same detection, but only when its own enable is on. Software clears each bit by pulsing a write-one-to-clear strobe for that bit. The pin shows as pending when either status bit is set. The request to the aggregator is the interrupt status gated by the unmask bit. A build option can register this request.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every output is 0. In the first clock cycle after reset is released, no edge is detected, whatever the input level.
- R2: In edge mode (`trig_level_i`=0) with polarity 2'b01, a 0-to-1 change of `lvl_i` between two consecutive clock edges sets the interrupt status at the second edge.
- R3: In edge mode with polarity 2'b00, a 1-to-0 change of `lvl_i` sets the interrupt status.
- R4: In edge mode with polarity 2'b10, either a 0-to-1 or a 1-to-0 change sets the interrupt status.
- R5: Polarity 2'b11 detects nothing, in either mode. Polarity 2'b10 detects nothing in level mode.
- R6: In level mode (`trig_level_i`=1), polarity 2'b01 detects while `lvl_i` is 1 and polarity 2'b00 detects while it is 0. A clear has no effect while the active level is still present.
- R7: When `int_en_i` is 0, a detection does not set the interrupt status.
- R8: A set interrupt status stays set until `int_clr_i` is pulsed. It reads 0 from the clock edge that samples the clear.
- R9: If a detection and a clear fall in the same cycle, the status stays set.
- R10: `irq_req_o` equals the interrupt status when `unmask_i` is 1 and is 0 when `unmask_i` is 0. The mask bit never changes the status.
- R11: When `wake_en_i` is 1, a detection sets the wake status, whatever the value of `int_en_i`. The wake status is sticky and is cleared only by `wake_clr_i`.
- R12: `pending_o` is 1 whenever either status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_i | input | 1 | Debounced pin level |
| trig_level_i | input | 1 | 1 = level sensing, 0 = edge sensing |
| act_i | input | ACT_BITS | Polarity: 00 low/falling, 01 high/rising, 10 both edges, 11 reserved |
| int_en_i | input | 1 | Interrupt detection enable |
| unmask_i | input | 1 | 1 forwards the request to the aggregator |
| wake_en_i | input | 1 | Wake detection enable |
| int_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt status |
| wake_clr_i | input | 1 | Write-one-to-clear strobe for the wake status |
| int_sts_o | output | 1 | Sticky interrupt status |
| wake_sts_o | output | 1 | Sticky wake status |
| pending_o | output | 1 | Either status bit set |
| irq_req_o | output | 1 | Masked request toward the aggregator |

## Verification
The assertions assume that every input is synchronous to `clk` and holds steady across each rising edge. They also assume that a clear strobe lasts one cycle per intended write, although longer pulses stay legal. The bench changes every input only on the falling clock edge and raises each clear strobe for exactly one cycle. It runs in edge and level modes under every polarity code, with the enable, wake-enable and mask bits in several combinations. It also includes cycles where a detection and a clear coincide.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Polarity codes; the numeric values are decoded by the sense stage
   typedef enum logic [1:0] {
      POL_LOW_FALL  = 2'b00,
      POL_HIGH_RISE = 2'b01,
      POL_BOTH      = 2'b10,
      POL_RSVD      = 2'b11
   } pol_e;

   localparam int POL_W   = 2;
   localparam int STS_NUM = 2;
   localparam int STS_INT = 0;
   localparam int STS_WAKE = 1;

endpackage

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
   import gpio_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_i,
   input  logic             trig_level_i,
   input  logic [POL_W-1:0] pol_i,
   output logic             hit_o
);

   logic lvl_q;
   logic hist_ok;
   logic rise;
   logic fall;
   logic edge_hit;
   logic level_hit;
   pol_e pol;

   assign pol = pol_e'(pol_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= 1'b0;
         hist_ok <= 1'b0;
      end else begin
         lvl_q   <= lvl_i;
         hist_ok <= 1'b1;
      end
   end

   assign rise = hist_ok &  lvl_i & ~lvl_q;
   assign fall = hist_ok & ~lvl_i &  lvl_q;

   always_comb begin
      edge_hit  = 1'b0;
      level_hit = 1'b0;
      unique case (pol)
         POL_LOW_FALL: begin
            edge_hit  = fall;
            level_hit = ~lvl_i;
         end
         POL_HIGH_RISE: begin
            edge_hit  = rise;
            level_hit = lvl_i;
         end
         POL_BOTH: begin
            edge_hit  = rise | fall;
            level_hit = 1'b0;
         end
         default: begin
            edge_hit  = 1'b0;
            level_hit = 1'b0;
         end
      endcase
   end

   assign hit_o = trig_level_i ? level_hit : edge_hit;

   // R2 R3 R4
   edge_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_level_i && hit_o) |-> (lvl_i != $past(lvl_i)));

   // R6
   level_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_level_i && hit_o) |-> (lvl_i == pol_i[0] && !pol_i[1]));

endmodule

// File: rtl/gpio_irq_sticky.sv
module gpio_irq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   // Setting outranks clearing when both arrive together
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int ACT_BITS = 2,
   parameter bit REQ_PIPE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lvl_i,
   input  logic                trig_level_i,
   input  logic [ACT_BITS-1:0] act_i,
   input  logic                int_en_i,
   input  logic                unmask_i,
   input  logic                wake_en_i,
   input  logic                int_clr_i,
   input  logic                wake_clr_i,
   output logic                int_sts_o,
   output logic                wake_sts_o,
   output logic                pending_o,
   output logic                irq_req_o
);

   generate
      if (ACT_BITS != POL_W) begin : g_bad_width
         $error("ACT_BITS must equal the polarity code width");
      end
   endgenerate

   logic               hit;
   logic [STS_NUM-1:0] sts_set;
   logic [STS_NUM-1:0] sts_clr;
   logic [STS_NUM-1:0] sts_q;

   gpio_irq_sense u_sense (
      .clk          (clk),
      .rst_n        (rst_n),
      .lvl_i        (lvl_i),
      .trig_level_i (trig_level_i),
      .pol_i        (act_i[POL_W-1:0]),
      .hit_o        (hit)
   );

   assign sts_set[STS_INT]  = hit & int_en_i;
   assign sts_set[STS_WAKE] = hit & wake_en_i;
   assign sts_clr[STS_INT]  = int_clr_i;
   assign sts_clr[STS_WAKE] = wake_clr_i;

   generate
      for (genvar k = 0; k < STS_NUM; k++) begin : g_sts
         gpio_irq_sticky u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (sts_set[k]),
            .clr_i (sts_clr[k]),
            .q_o   (sts_q[k])
         );
      end
   endgenerate

   assign int_sts_o  = sts_q[STS_INT];
   assign wake_sts_o = sts_q[STS_WAKE];
   assign pending_o  = |sts_q;

   generate
      if (REQ_PIPE) begin : g_req_reg
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= sts_q[STS_INT] & unmask_i;
         end
         assign irq_req_o = req_q;

         // R10
         req_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req_o |-> $past(unmask_i));
      end else begin : g_req_comb
         assign irq_req_o = sts_q[STS_INT] & unmask_i;

         // R10
         req_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req_o |-> (unmask_i && int_sts_o));
      end
   endgenerate

   // R7
   en_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_sts_o) |-> $past(int_en_i));

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_sts_o && !int_clr_i) |=> int_sts_o);

   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_clr_i && !(hit && int_en_i)) |=> !int_sts_o);

   // R5
   rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == 2'b11) |-> !hit);

   // R11
   wake_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_sts_o) |-> $past(wake_en_i));

   // R12
   pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_sts_o || wake_sts_o) |-> pending_o);

endmodule

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lvl = 1'b0, trig_level = 1'b0, int_en = 1'b0, unmask = 1'b0;
   logic wake_en = 1'b0, int_clr = 1'b0, wake_clr = 1'b0;
   logic [1:0] act = 2'b01;
   logic int_sts, wake_sts, pending, irq_req;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   string tag = "R1";

   // reference state
   bit m_prev, m_primed, m_int, m_wake;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_detect u0 (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .trig_level_i(trig_level),
      .act_i(act), .int_en_i(int_en), .unmask_i(unmask), .wake_en_i(wake_en),
      .int_clr_i(int_clr), .wake_clr_i(wake_clr), .int_sts_o(int_sts),
      .wake_sts_o(wake_sts), .pending_o(pending), .irq_req_o(irq_req)
   );

   always @(posedge clk or negedge rst_n) begin
      bit det;
      if (!rst_n) begin
         m_prev = 0; m_primed = 0; m_int = 0; m_wake = 0;
      end else begin
         det = 0;
         if (trig_level) begin
            if (act == 2'b01) det = lvl;
            else if (act == 2'b00) det = !lvl;
         end else if (m_primed) begin
            if (act == 2'b01) det = lvl && !m_prev;
            else if (act == 2'b00) det = !lvl && m_prev;
            else if (act == 2'b10) det = lvl != m_prev;
         end
         m_int  = (det && int_en)  || (m_int  && !int_clr);
         m_wake = (det && wake_en) || (m_wake && !wake_clr);
         m_prev = lvl;
         m_primed = 1;
      end
   end

   task automatic check(string req, string what, logic act_v, logic exp_v);
      checks++;
      if (act_v !== exp_v) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act_v, exp_v, $time);
      end
   endtask

   task automatic compare_model();
      check(tag, "int_sts", int_sts, m_int);
      check(tag, "wake_sts", wake_sts, m_wake);
      check(tag, "pending", pending, m_int || m_wake);
      check(tag, "irq_req", irq_req, m_int && unmask);
   endtask

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         compare_model();
         int_clr = 0;
         wake_clr = 0;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      lvl = 1; int_en = 1; unmask = 1; act = 2'b01;
      repeat (2) @(negedge clk);
      tag = "R1";
      check("R1", "int_sts in reset", int_sts, 1'b0);
      check("R1", "pending in reset", pending, 1'b0);
      check("R1", "irq_req in reset", irq_req, 1'b0);
      rst_n = 1;
      tick(1);
      check("R1", "no edge after reset", int_sts, 1'b0);

      // R2 rising edge
      tag = "R2"; lvl = 0; tick(1);
      lvl = 1; tick(1);
      check("R2", "rise sets status", int_sts, 1'b1);
      check("R10", "req when unmasked", irq_req, 1'b1);
      tag = "R8"; tick(3);
      check("R8", "sticky", int_sts, 1'b1);
      int_clr = 1; tick(1);
      check("R8", "cleared", int_sts, 1'b0);
      lvl = 0; tick(1);
      check("R2", "falling ignored", int_sts, 1'b0);

      // R3 falling edge
      tag = "R3"; act = 2'b00; lvl = 1; tick(1);
      check("R3", "rise ignored", int_sts, 1'b0);
      lvl = 0; tick(1);
      check("R3", "fall sets", int_sts, 1'b1);
      int_clr = 1; tick(1);

      // R4 both edges
      tag = "R4"; act = 2'b10; lvl = 1; tick(1);
      check("R4", "rise sets", int_sts, 1'b1);
      int_clr = 1; tick(1);
      lvl = 0; tick(1);
      check("R4", "fall sets", int_sts, 1'b1);
      int_clr = 1; tick(1);

      // R5 reserved and level-both
      tag = "R5"; act = 2'b11;
      for (int i = 0; i < 4; i++) begin lvl = ~lvl; tick(1); end
      check("R5", "reserved edge", int_sts, 1'b0);
      trig_level = 1; lvl = 1; tick(2);
      check("R5", "reserved level", int_sts, 1'b0);
      act = 2'b10; lvl = 0; tick(2); lvl = 1; tick(2);
      check("R5", "level both quiet", int_sts, 1'b0);

      // R6 level sensing
      tag = "R6"; act = 2'b01; tick(1);
      check("R6", "high level sets", int_sts, 1'b1);
      int_clr = 1; tick(1);
      check("R6", "reasserts after clear", int_sts, 1'b1);
      lvl = 0; int_clr = 1; tick(1);
      check("R6", "clear once level gone", int_sts, 1'b0);
      act = 2'b00; tick(1);
      check("R6", "low level sets", int_sts, 1'b1);
      trig_level = 0; act = 2'b01; int_clr = 1; tick(1);

      // R7 enable off
      tag = "R7"; int_en = 0; lvl = 1; tick(1);
      check("R7", "disabled edge lost", int_sts, 1'b0);
      int_en = 1; lvl = 0; tick(1);

      // R9 detection beats clear
      tag = "R9"; lvl = 1; int_clr = 1; tick(1);
      check("R9", "detect wins", int_sts, 1'b1);

      // R10 mask
      tag = "R10"; unmask = 0; tick(1);
      check("R10", "masked req", irq_req, 1'b0);
      check("R10", "status unaffected", int_sts, 1'b1);
      unmask = 1; tick(1);
      check("R10", "unmasked req", irq_req, 1'b1);
      int_clr = 1; tick(1);

      // R11 / R12 wake
      tag = "R11"; int_en = 0; wake_en = 1; lvl = 0; tick(1);
      lvl = 1; tick(1);
      check("R11", "wake set", wake_sts, 1'b1);
      check("R11", "int not set", int_sts, 1'b0);
      check("R12", "pending from wake", pending, 1'b1);
      int_clr = 1; tick(1);
      check("R11", "int clear leaves wake", wake_sts, 1'b1);
      wake_clr = 1; tick(1);
      check("R11", "wake cleared", wake_sts, 1'b0);
      check("R12", "pending dropped", pending, 1'b0);

      // mixed sweep
      tag = "R12"; int_en = 1; unmask = 1;
      for (int i = 0; i < 40; i++) begin
         lvl = (i % 3) == 0;
         act = 2'(i % 4);
         trig_level = (i % 7) == 3;
         wake_en = (i % 5) < 2;
         int_clr = (i % 6) == 0;
         wake_clr = (i % 4) == 1;
         unmask = (i % 9) != 2;
         tick(1);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule